// File: doc/BRIEF.md
# Parallel Test-Mode Data Compressor

This block sits between four external data pins and a storage array that is eight bits wide at every address, so that the memory looks one bit deeper and half as wide from outside. In the normal mode the lowest column address bit chooses which of the two internal bits belonging to a pin is read or written. The other internal bit is left alone.

In the test mode the lowest column address bit has no effect. A write copies each pin's value into both of its internal bits. A read returns one agreement bit per pin, which is 1 when the pin's two stored bits are equal. A whole array can therefore be checked in half the number of accesses.

The mode register follows the refresh cycle types that an upstream cycle decoder reports on a strobe at the row strobe's falling edge. The block also flags the cycles that refresh from the internal row counter.

Top module: `tcmp_unit`

## Requirements
- R1: After reset `test_mode` is 0, and it changes only on a clock edge at which `cyc_valid` is 1.
- R2: Normal-mode write with `wr_en`=1: for each pin p, `arr_wmask` bit 2p+`col_lsb` is 1 and bit 2p+1-`col_lsb` is 0, so exactly four mask bits are set.
- R3: Normal-mode read: `pin_rdata[p]` equals `arr_rdata[2p+col_lsb]`.
- R4: Test-mode write with `wr_en`=1: all eight `arr_wmask` bits are 1 whatever `col_lsb` is, and `arr_wdata` bits 2p and 2p+1 both carry `pin_wdata[p]`. In both modes `arr_wdata` bits 2p and 2p+1 equal `pin_wdata[p]`.
- R5: Test-mode read: `pin_rdata[p]` is 1 when `arr_rdata[2p]` equals `arr_rdata[2p+1]` and 0 otherwise, whatever `col_lsb` is.
- R6: A strobe with `cyc_kind`=2'b11 (write-enable and column-before-row refresh) sets `test_mode` from the next clock edge on, and it keeps `test_mode` set when the block is already in the test mode.
- R7: A strobe with `cyc_kind`=2'b10 (column-before-row refresh) or 2'b01 (row-only refresh) clears `test_mode` at the next clock edge.
- R8: A strobe with `cyc_kind`=2'b00 (ordinary access) leaves `test_mode` unchanged.
- R9: `counter_refresh` is 1 while `cyc_valid` is 1 and `cyc_kind` is 2'b10 or 2'b11, in either mode. It is 0 for 2'b00, for 2'b01 and whenever there is no strobe.
- R10: With `wr_en`=0, `arr_wmask` is all zero in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_valid | input | 1 | Cycle-type strobe at the row strobe's falling edge |
| cyc_kind | input | 2 | Decoded cycle type (00 access, 01 row-only, 10 column-before-row, 11 write-enable column-before-row) |
| counter_refresh | output | 1 | Current cycle refreshes from the internal row counter |
| test_mode | output | 1 | 1 while the compressed test mode is active |
| col_lsb | input | 1 | Lowest column address bit |
| wr_en | input | 1 | Write access in progress |
| pin_wdata | input | 4 | Data from the external pins |
| arr_wdata | output | 8 | Data toward the array |
| arr_wmask | output | 8 | Per-bit write enables toward the array |
| arr_rdata | input | 8 | Data read from the array |
| pin_rdata | output | 4 | Data toward the external pins |

## Verification
The bench stores the same stored byte under both column bit values and both modes. A design that ignored `col_lsb` in the normal mode, or still used it in the test mode, would return the wrong pin in one of those pairs. Test-mode reads cover the mixed pairs 01 and 10 as well as the uniform pairs 00 and 11. This exposes a fold that uses OR or AND logic, or one that reports disagreement as 1. The mode walk sends a write-enable refresh while the block is already in the test mode, and it sends access strobes in both modes. A decoder that toggled the mode, or treated the access type as an exit, would then show the wrong `test_mode`. Row-only and column-before-row refreshes are checked both as exits and against `counter_refresh`.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [1:0] {
    CYC_ACCESS   = 2'b00,
    CYC_ROW_ONLY = 2'b01,
    CYC_CBR      = 2'b10,
    CYC_WE_CBR   = 2'b11
  } cyc_kind_t;

  // Cycles that take the row from the internal refresh counter
  function automatic logic uses_row_counter(input cyc_kind_t k);
    return (k == CYC_CBR) || (k == CYC_WE_CBR);
  endfunction

  // Mode after a strobed cycle of kind k when the present mode is cur
  function automatic logic mode_after(input cyc_kind_t k, input logic cur);
    case (k)
      CYC_WE_CBR:           return 1'b1;
      CYC_CBR, CYC_ROW_ONLY: return 1'b0;
      default:              return cur;
    endcase
  endfunction

endpackage

// File: rtl/tcmp_mode_ctl.sv
module tcmp_mode_ctl
  import tcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cyc_valid,
  input  cyc_kind_t cyc_kind,
  output logic      test_mode,
  output logic      counter_refresh
);

  logic mode_q;
  logic mode_d;

  always_comb begin
    mode_d = mode_q;
    if (cyc_valid) mode_d = mode_after(cyc_kind, mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign test_mode       = mode_q;
  assign counter_refresh = cyc_valid && uses_row_counter(cyc_kind);

  assert_enter_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == CYC_WE_CBR) |=> test_mode);

  assert_exit_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_kind == CYC_CBR || cyc_kind == CYC_ROW_ONLY)) |=> !test_mode);

  assert_hold_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid || cyc_kind == CYC_ACCESS) |=> $stable(test_mode));

  assert_counter_in_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && cyc_valid && cyc_kind == CYC_WE_CBR) |-> counter_refresh);

endmodule

// File: rtl/tcmp_write_fan.sv
module tcmp_write_fan #(
  parameter int PINS = 4,
  parameter int WAYS = 2,
  localparam int SEL_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int BITS  = PINS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] col_sel,
  input  logic [PINS-1:0]  pin_wdata,
  output logic [BITS-1:0]  arr_wdata,
  output logic [BITS-1:0]  arr_wmask
);

  // One internal bit is written when its way is picked, or all in test mode
  function automatic logic way_hit(input logic tm, input logic [SEL_W-1:0] sel,
                                   input int way);
    return tm || (int'(sel) == way);
  endfunction

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign arr_wdata[p*WAYS + w] = pin_wdata[p];
      assign arr_wmask[p*WAYS + w] = wr_en && way_hit(test_mode, col_sel, w);
    end
  end

  assert_test_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && test_mode) |-> (&arr_wmask));

  assert_normal_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !test_mode) |-> ($countones(arr_wmask) == PINS));

  assert_idle_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (arr_wmask == '0));

endmodule

// File: rtl/tcmp_read_fold.sv
module tcmp_read_fold #(
  parameter int PINS = 4,
  parameter int WAYS = 2,
  localparam int SEL_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int BITS  = PINS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic [SEL_W-1:0] col_sel,
  input  logic [BITS-1:0]  arr_rdata,
  output logic [PINS-1:0]  pin_rdata
);

  // 1 when every stored copy of one pin holds the same value
  function automatic logic ways_agree(input logic [WAYS-1:0] s);
    return (s == '0) || (s == '1);
  endfunction

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [WAYS-1:0] slice;
    logic            agree;
    logic            picked;
    assign slice  = arr_rdata[p*WAYS +: WAYS];
    assign agree  = ways_agree(slice);
    assign picked = slice[col_sel];
    assign pin_rdata[p] = test_mode ? agree : picked;
  end

  assert_fold_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && (arr_rdata == '0 || arr_rdata == '1)) |-> (&pin_rdata));

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int PINS = 4,
  parameter int WAYS = 2,
  localparam int SEL_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int BITS  = PINS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  input  logic [1:0]       cyc_kind,
  output logic             counter_refresh,
  output logic             test_mode,
  input  logic [SEL_W-1:0] col_lsb,
  input  logic             wr_en,
  input  logic [PINS-1:0]  pin_wdata,
  output logic [BITS-1:0]  arr_wdata,
  output logic [BITS-1:0]  arr_wmask,
  input  logic [BITS-1:0]  arr_rdata,
  output logic [PINS-1:0]  pin_rdata
);

  cyc_kind_t kind;
  logic      mode_now;

  assign kind      = cyc_kind_t'(cyc_kind);
  assign test_mode = mode_now;

  tcmp_mode_ctl u_mode (
    .clk             (clk),
    .rst_n           (rst_n),
    .cyc_valid       (cyc_valid),
    .cyc_kind        (kind),
    .test_mode       (mode_now),
    .counter_refresh (counter_refresh)
  );

  tcmp_write_fan #(.PINS(PINS), .WAYS(WAYS)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (mode_now),
    .wr_en     (wr_en),
    .col_sel   (col_lsb),
    .pin_wdata (pin_wdata),
    .arr_wdata (arr_wdata),
    .arr_wmask (arr_wmask)
  );

  tcmp_read_fold #(.PINS(PINS), .WAYS(WAYS)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (mode_now),
    .col_sel   (col_lsb),
    .arr_rdata (arr_rdata),
    .pin_rdata (pin_rdata)
  );

  assert_mode_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> $stable(test_mode));

endmodule

// File: tb/sim_tcmp_unit.sv
module sim_tcmp_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_valid = 1'b0;
  logic [1:0] cyc_kind = 2'b00;
  logic       counter_refresh;
  logic       test_mode;
  logic [0:0] col_lsb = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] pin_wdata = 4'h0;
  logic [7:0] arr_wdata;
  logic [7:0] arr_wmask;
  logic [7:0] arr_rdata = 8'h00;
  logic [3:0] pin_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_mode = 1'b0;

  always #5 clk = ~clk;

  tcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
    .counter_refresh(counter_refresh), .test_mode(test_mode),
    .col_lsb(col_lsb), .wr_en(wr_en), .pin_wdata(pin_wdata),
    .arr_wdata(arr_wdata), .arr_wmask(arr_wmask),
    .arr_rdata(arr_rdata), .pin_rdata(pin_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Strobe one cycle type, check the refresh flag, then the mode after the edge
  task automatic strobe(input logic [1:0] k, input logic exp_flag, input string tag);
    @(negedge clk);
    cyc_valid = 1'b1;
    cyc_kind  = k;
    #1;
    chk({tag, " counter_refresh R9"}, {7'd0, counter_refresh}, {7'd0, exp_flag});
    if (k == 2'b11) exp_mode = 1'b1;
    else if (k != 2'b00) exp_mode = 1'b0;
    @(negedge clk);
    cyc_valid = 1'b0;
    cyc_kind  = 2'b00;
    #1;
    chk({tag, " test_mode"}, {7'd0, test_mode}, {7'd0, exp_mode});
  endtask

  // mode, lsb, pin_wdata, arr_rdata, exp mask, exp wdata, exp pin_rdata
  typedef struct packed {
    logic       mode;
    logic       lsb;
    logic [3:0] wd;
    logic [7:0] rd;
    logic [7:0] mask;
    logic [7:0] wdat;
    logic [3:0] pins;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 4'b1010, 8'b10011100, 8'h55, 8'b11001100, 4'b0110},
    '{1'b0, 1'b1, 4'b0101, 8'b10011100, 8'hAA, 8'b00110011, 4'b1010},
    '{1'b1, 1'b0, 4'b1010, 8'b10011100, 8'hFF, 8'b11001100, 4'b0011},
    '{1'b1, 1'b1, 4'b0110, 8'b00111001, 8'hFF, 8'b00111100, 4'b1100},
    '{1'b0, 1'b0, 4'b1111, 8'hFF,       8'h55, 8'hFF,       4'b1111},
    '{1'b1, 1'b0, 4'b0000, 8'h55,       8'hFF, 8'h00,       4'b0000},
    '{1'b1, 1'b1, 4'b1111, 8'h00,       8'hFF, 8'hFF,       4'b1111},
    '{1'b0, 1'b1, 4'b0000, 8'h55,       8'hAA, 8'h00,       4'b0000}
  };

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("reset test_mode R1", {7'd0, test_mode}, 8'd0);
    chk("reset idle mask R10", arr_wmask, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("no strobe keeps normal R1", {7'd0, test_mode}, 8'd0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      if (VECS[i].mode != exp_mode)
        strobe(VECS[i].mode ? 2'b11 : 2'b10, 1'b1, "table mode set R6 R7");
      @(negedge clk);
      col_lsb   = VECS[i].lsb;
      pin_wdata = VECS[i].wd;
      arr_rdata = VECS[i].rd;
      wr_en     = 1'b1;
      #1;
      chk(VECS[i].mode ? "test mask R4" : "normal mask R2", arr_wmask, VECS[i].mask);
      chk("write data R4", arr_wdata, VECS[i].wdat);
      chk(VECS[i].mode ? "test fold R5" : "normal select R3",
          {4'd0, pin_rdata}, {4'd0, VECS[i].pins});
    end

    // Directed: idle write in test mode, mode walk corners
    strobe(2'b11, 1'b1, "enter R6");
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("test idle mask R10", arr_wmask, 8'h00);
    strobe(2'b11, 1'b1, "re-enter stays test R6");
    strobe(2'b00, 1'b0, "access in test R8");
    strobe(2'b01, 1'b0, "row-only exit R7");
    @(negedge clk);
    #1;
    chk("normal idle mask R10", arr_wmask, 8'h00);
    strobe(2'b00, 1'b0, "access in normal R8");
    strobe(2'b10, 1'b1, "cbr in normal R7");
    strobe(2'b11, 1'b1, "enter again R6");
    strobe(2'b10, 1'b1, "cbr exit R7");

    @(negedge clk);
    #1;
    chk("no strobe flag R9", {7'd0, counter_refresh}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule